// File: doc/BRIEF.md
# PHY Packet Statistics Counter

This block keeps frame statistics for one Ethernet PHY. Each direction has a 32-bit count of frames seen and a 16-bit count of frames that ended with a bad CRC. The receive and transmit datapaths each signal a finished frame with a one-cycle strobe, plus a CRC-bad flag that is valid in the same cycle. The error counts advance only while CRC checking is switched on.

Software reaches the block through a 16-bit register port with an address, a read strobe, a write strobe and write data. One control register turns on CRC checking and clear-on-read. Six counter registers hold the counts. A 32-bit frame count is read as two halves, upper half first. Reading the upper half captures the lower half, so the second read comes from the same moment as the first. With clear-on-read set, software can read the halves, add them to a wide running total and never lose an event.

Top module: `phy_pkt_stats`

## Requirements
- R1: After reset, every counter, the low-half snapshots, the control register and the read data are zero.
- R2: The control register sits at 0x8029. Bit 0 is CRC-check enable and bit 1 is clear-on-read enable. Both are written from the write data and read back in place, and bits 15:2 always read as 0.
- R3: Each frame-end strobe advances the 32-bit frame count of its direction by one, whether or not the CRC flag is set. The count wraps modulo 2^32.
- R4: A direction's error count advances on a frame-end strobe with the CRC-bad flag set, and only while control bit 0 is 1.
- R5: The 16-bit error counts hold at 0xFFFF and do not wrap.
- R6: Receive registers are 0x802A for frame bits 31:16, 0x802B for frame bits 15:0 and 0x802C for errors. Transmit registers are 0x802D, 0x802E and 0x802F in the same roles. Reading an upper half returns bits 31:16 and captures bits 15:0. Reading the lower half returns the value captured by the most recent upper-half read.
- R7: With control bit 1 set, reading an upper half clears the whole 32-bit count, and reading an error register clears that error count. A lower-half read clears nothing.
- R8: If an event arrives in the same cycle as a clearing read of its counter, the counter becomes 1, not 0.
- R9: With control bit 1 clear, reads leave every counter unchanged and counting goes on.
- R10: Reads of any address outside 0x8029 to 0x802F return 0 and change no state. Writes to any address other than 0x8029 are ignored.
- R11: Read data appears on the cycle after the read strobe and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_frame_end | input | 1 | Receive frame finished, one cycle |
| rx_crc_bad | input | 1 | Receive frame had a CRC error, valid with rx_frame_end |
| tx_frame_end | input | 1 | Transmit frame finished, one cycle |
| tx_crc_bad | input | 1 | Transmit frame had a CRC error, valid with tx_frame_end |
| mgmt_addr | input | 16 | Register address |
| mgmt_rd | input | 1 | Read strobe |
| mgmt_wr | input | 1 | Write strobe |
| mgmt_wdata | input | 16 | Write data |
| mgmt_rdata | output | 16 | Registered read data |

## Verification
The bench reads the lower half after the counter has moved on since the upper-half read. A design without a snapshot would return the live count there, not the captured one. It puts a frame event in the same cycle as a clearing read, which catches a design that drops that event and shows 0 where 1 belongs. It drives more than 65535 bad transmit frames, so an error counter that wraps shows a small value where 0xFFFF is expected. The same run carries the frame count past bit 15, which catches halves that are swapped. Reads of unmapped addresses and writes to counter addresses are each followed by reads of the counters, which show whether those accesses cleared or changed anything.

// File: rtl/phy_stats_pkg.sv
package phy_stats_pkg;
  // register placement: the control word, then three registers per direction
  localparam int unsigned ADDR_CTRL    = 32'h8029;
  localparam int unsigned ADDR_CH0     = 32'h802A;
  localparam int unsigned CH_STRIDE    = 3;
  localparam int unsigned OFS_HI       = 0;
  localparam int unsigned OFS_LO       = 1;
  localparam int unsigned OFS_ERR      = 2;
  localparam int unsigned CTRL_CRC_BIT = 0;
  localparam int unsigned CTRL_CLR_BIT = 1;
  localparam int unsigned NUM_CH       = 2; // index 0 receive, 1 transmit
endpackage

// File: rtl/stats_addr_dec.sv
module stats_addr_dec
  import phy_stats_pkg::*;
#(
  parameter int AW  = 16,
  parameter int NCH = 2
) (
  input  logic [AW-1:0]  addr,
  output logic           hit_ctrl,
  output logic [NCH-1:0] hit_hi,
  output logic [NCH-1:0] hit_lo,
  output logic [NCH-1:0] hit_err
);
  assign hit_ctrl = (addr == AW'(ADDR_CTRL));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int unsigned BASE = ADDR_CH0 + CH_STRIDE * g;
    assign hit_hi[g]  = (addr == AW'(BASE + OFS_HI));
    assign hit_lo[g]  = (addr == AW'(BASE + OFS_LO));
    assign hit_err[g] = (addr == AW'(BASE + OFS_ERR));
  end
endmodule

// File: rtl/stats_pkt_cnt.sv
module stats_pkt_cnt #(
  parameter int CW = 32,
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev,
  input  logic          grab,
  input  logic          clr,
  output logic [CW-1:0] count,
  output logic [HW-1:0] snap
);
  function automatic logic [CW-1:0] pkt_next(input logic [CW-1:0] cur,
                                              input logic ev_i,
                                              input logic clr_i);
    if (clr_i) return CW'(ev_i);
    return cur + CW'(ev_i);
  endfunction

  logic [CW-1:0] count_nxt;
  assign count_nxt = pkt_next(count, ev, clr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      snap  <= '0;
    end else begin
      count <= count_nxt;
      if (grab) snap <= count[HW-1:0];
    end
  end
endmodule

// File: rtl/stats_err_cnt.sv
module stats_err_cnt #(
  parameter int EW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev,
  input  logic          clr,
  output logic [EW-1:0] count
);
  function automatic logic [EW-1:0] err_next(input logic [EW-1:0] cur,
                                              input logic ev_i,
                                              input logic clr_i);
    if (clr_i) return EW'(ev_i);
    if (ev_i && (cur != '1)) return cur + EW'(1);
    return cur;
  endfunction

  logic [EW-1:0] count_nxt;
  assign count_nxt = err_next(count, ev, clr);

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count_nxt;
  end
endmodule

// File: rtl/phy_pkt_stats.sv
module phy_pkt_stats
  import phy_stats_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int ERR_W = 16,
  parameter int REG_W = 16,
  parameter int AW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_frame_end,
  input  logic             rx_crc_bad,
  input  logic             tx_frame_end,
  input  logic             tx_crc_bad,
  input  logic [AW-1:0]    mgmt_addr,
  input  logic             mgmt_rd,
  input  logic             mgmt_wr,
  input  logic [REG_W-1:0] mgmt_wdata,
  output logic [REG_W-1:0] mgmt_rdata
);
  localparam int NCH  = NUM_CH;
  localparam int HI_W = CNT_W - REG_W;

  logic ctrl_crc_q, ctrl_clr_q;
  logic hit_ctrl;
  logic [NCH-1:0] hit_hi, hit_lo, hit_err;
  logic [NCH-1:0] ch_fe, ch_bad;
  logic [NCH-1:0] hi_rd, pkt_clr, err_clr, err_ev;
  logic [CNT_W-1:0] pkt_cnt [NCH];
  logic [REG_W-1:0] pkt_snap [NCH];
  logic [ERR_W-1:0] err_cnt [NCH];
  logic [REG_W-1:0] rd_val;

  // named views for the checker
  logic [CNT_W-1:0] rx_pkt_q, tx_pkt_q;
  logic [REG_W-1:0] rx_snap_q, tx_snap_q;
  logic [ERR_W-1:0] rx_err_q, tx_err_q;

  wire unused_wdata = ^mgmt_wdata[REG_W-1:2];

  assign ch_fe  = {tx_frame_end, rx_frame_end};
  assign ch_bad = {tx_crc_bad, rx_crc_bad};

  stats_addr_dec #(.AW(AW), .NCH(NCH)) u_dec (
    .addr     (mgmt_addr),
    .hit_ctrl (hit_ctrl),
    .hit_hi   (hit_hi),
    .hit_lo   (hit_lo),
    .hit_err  (hit_err)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign hi_rd[g]   = mgmt_rd & hit_hi[g];
    assign pkt_clr[g] = hi_rd[g] & ctrl_clr_q;
    assign err_clr[g] = mgmt_rd & hit_err[g] & ctrl_clr_q;
    assign err_ev[g]  = ch_fe[g] & ch_bad[g] & ctrl_crc_q;

    stats_pkt_cnt #(.CW(CNT_W), .HW(REG_W)) u_pkt (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (ch_fe[g]),
      .grab  (hi_rd[g]),
      .clr   (pkt_clr[g]),
      .count (pkt_cnt[g]),
      .snap  (pkt_snap[g])
    );

    stats_err_cnt #(.EW(ERR_W)) u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (err_ev[g]),
      .clr   (err_clr[g]),
      .count (err_cnt[g])
    );
  end

  assign rx_pkt_q  = pkt_cnt[0];
  assign tx_pkt_q  = pkt_cnt[1];
  assign rx_snap_q = pkt_snap[0];
  assign tx_snap_q = pkt_snap[1];
  assign rx_err_q  = err_cnt[0];
  assign tx_err_q  = err_cnt[1];

  always_comb begin
    rd_val = '0;
    if (hit_ctrl) begin
      rd_val[CTRL_CRC_BIT] = ctrl_crc_q;
      rd_val[CTRL_CLR_BIT] = ctrl_clr_q;
    end
    for (int c = 0; c < NCH; c++) begin
      if (hit_hi[c])  rd_val = REG_W'(pkt_cnt[c][CNT_W-1 -: HI_W]);
      if (hit_lo[c])  rd_val = pkt_snap[c];
      if (hit_err[c]) rd_val = REG_W'(err_cnt[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_crc_q <= 1'b0;
      ctrl_clr_q <= 1'b0;
      mgmt_rdata <= '0;
    end else begin
      if (mgmt_wr && hit_ctrl) begin
        ctrl_crc_q <= mgmt_wdata[CTRL_CRC_BIT];
        ctrl_clr_q <= mgmt_wdata[CTRL_CLR_BIT];
      end
      if (mgmt_rd) mgmt_rdata <= rd_val;
    end
  end
endmodule

// File: rtl/phy_pkt_stats_chk.sv
module phy_pkt_stats_chk
  import phy_stats_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int ERR_W = 16,
  parameter int REG_W = 16,
  parameter int AW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_frame_end,
  input logic             rx_crc_bad,
  input logic             tx_frame_end,
  input logic             tx_crc_bad,
  input logic [AW-1:0]    mgmt_addr,
  input logic             mgmt_rd,
  input logic             mgmt_wr,
  input logic [REG_W-1:0] mgmt_wdata,
  input logic [REG_W-1:0] mgmt_rdata,
  input logic             ctrl_crc_q,
  input logic             ctrl_clr_q,
  input logic [CNT_W-1:0] rx_pkt_q,
  input logic [CNT_W-1:0] tx_pkt_q,
  input logic [REG_W-1:0] rx_snap_q,
  input logic [REG_W-1:0] tx_snap_q,
  input logic [ERR_W-1:0] rx_err_q,
  input logic [ERR_W-1:0] tx_err_q
);
  logic rx_hi_rd, tx_hi_rd, rx_pclr, tx_pclr, rx_eclr, tx_eclr, mapped;
  assign rx_hi_rd = mgmt_rd && (mgmt_addr == AW'(ADDR_CH0 + OFS_HI));
  assign tx_hi_rd = mgmt_rd && (mgmt_addr == AW'(ADDR_CH0 + CH_STRIDE + OFS_HI));
  assign rx_pclr  = rx_hi_rd && ctrl_clr_q;
  assign tx_pclr  = tx_hi_rd && ctrl_clr_q;
  assign rx_eclr  = mgmt_rd && ctrl_clr_q && (mgmt_addr == AW'(ADDR_CH0 + OFS_ERR));
  assign tx_eclr  = mgmt_rd && ctrl_clr_q && (mgmt_addr == AW'(ADDR_CH0 + CH_STRIDE + OFS_ERR));
  assign mapped   = (mgmt_addr >= AW'(ADDR_CTRL)) && (mgmt_addr <= AW'(ADDR_CTRL + 6));

  // R3: frame counts step by the frame strobe when not cleared
  p_rx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_pclr |=> rx_pkt_q == $past(rx_pkt_q) + CNT_W'($past(rx_frame_end)));
  p_tx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_pclr |=> tx_pkt_q == $past(tx_pkt_q) + CNT_W'($past(tx_frame_end)));

  // R8: a clearing read keeps a coincident event
  p_rx_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pclr |=> rx_pkt_q == CNT_W'($past(rx_frame_end)));
  p_tx_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pclr |=> tx_pkt_q == CNT_W'($past(tx_frame_end)));

  // R4: no error counting with CRC checking off
  p_rx_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_crc_q && !rx_eclr) |=> $stable(rx_err_q));
  p_tx_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_crc_q && !tx_eclr) |=> $stable(tx_err_q));
  p_rx_errstep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_crc_q && !rx_eclr && rx_frame_end && rx_crc_bad && rx_err_q != '1)
    |=> rx_err_q == $past(rx_err_q) + ERR_W'(1));
  p_tx_errstep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_crc_q && !tx_eclr && tx_frame_end && tx_crc_bad && tx_err_q != '1)
    |=> tx_err_q == $past(tx_err_q) + ERR_W'(1));

  // R5: saturation
  p_rx_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err_q == '1 && !rx_eclr) |=> rx_err_q == '1);
  p_tx_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_err_q == '1 && !tx_eclr) |=> tx_err_q == '1);

  // R6: upper-half read captures the lower half
  p_rx_snap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hi_rd |=> rx_snap_q == $past(rx_pkt_q[REG_W-1:0]));
  p_tx_snap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_hi_rd |=> tx_snap_q == $past(tx_pkt_q[REG_W-1:0]));

  // R2: control write and unused bits
  p_ctrl_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_wr && mgmt_addr == AW'(ADDR_CTRL))
    |=> (ctrl_crc_q == $past(mgmt_wdata[CTRL_CRC_BIT])) && (ctrl_clr_q == $past(mgmt_wdata[CTRL_CLR_BIT])));
  p_ctrl_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_rd && mgmt_addr == AW'(ADDR_CTRL)) |=> mgmt_rdata[REG_W-1:2] == '0);

  // R10: unmapped reads
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_rd && !mapped) |=> mgmt_rdata == '0);

  // R11: read data held between reads
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mgmt_rd |=> $stable(mgmt_rdata));
endmodule

bind phy_pkt_stats phy_pkt_stats_chk #(
  .CNT_W(CNT_W), .ERR_W(ERR_W), .REG_W(REG_W), .AW(AW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_frame_end (rx_frame_end),
  .rx_crc_bad   (rx_crc_bad),
  .tx_frame_end (tx_frame_end),
  .tx_crc_bad   (tx_crc_bad),
  .mgmt_addr    (mgmt_addr),
  .mgmt_rd      (mgmt_rd),
  .mgmt_wr      (mgmt_wr),
  .mgmt_wdata   (mgmt_wdata),
  .mgmt_rdata   (mgmt_rdata),
  .ctrl_crc_q   (ctrl_crc_q),
  .ctrl_clr_q   (ctrl_clr_q),
  .rx_pkt_q     (rx_pkt_q),
  .tx_pkt_q     (tx_pkt_q),
  .rx_snap_q    (rx_snap_q),
  .tx_snap_q    (tx_snap_q),
  .rx_err_q     (rx_err_q),
  .tx_err_q     (tx_err_q)
);

// File: tb/phy_pkt_stats_bench.sv
module phy_pkt_stats_bench;
  localparam int CLK_P = 10;
  localparam logic [15:0] A_CTRL = 16'h8029, A_RXH = 16'h802A, A_RXL = 16'h802B,
                          A_RXE = 16'h802C, A_TXH = 16'h802D, A_TXL = 16'h802E,
                          A_TXE = 16'h802F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_frame_end = 0, rx_crc_bad = 0, tx_frame_end = 0, tx_crc_bad = 0;
  logic [15:0] mgmt_addr = '0, mgmt_wdata = '0;
  logic mgmt_rd = 0, mgmt_wr = 0;
  logic [15:0] mgmt_rdata;

  int tests = 0, fails = 0;
  bit done = 0;

  // behavioural reference state
  longint m_pkt [2];
  int m_err [2], m_snap [2];
  int m_ctrl = 0, m_rdata = 0;

  always #(CLK_P/2) clk = ~clk;

  phy_pkt_stats u_phy_pkt_stats (
    .clk(clk), .rst_n(rst_n),
    .rx_frame_end(rx_frame_end), .rx_crc_bad(rx_crc_bad),
    .tx_frame_end(tx_frame_end), .tx_crc_bad(tx_crc_bad),
    .mgmt_addr(mgmt_addr), .mgmt_rd(mgmt_rd), .mgmt_wr(mgmt_wr),
    .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge(input bit [1:0] fe, input bit [1:0] bad, input bit rd,
                            input bit wr, input int addr, input int wdata);
    int base;
    if (rd) begin
      m_rdata = 0;
      if (addr == A_CTRL) m_rdata = m_ctrl;
      for (int c = 0; c < 2; c++) begin
        base = 'h802A + 3 * c;
        if (addr == base)     m_rdata = int'(m_pkt[c] / 65536);
        if (addr == base + 1) m_rdata = m_snap[c];
        if (addr == base + 2) m_rdata = m_err[c];
      end
    end
    for (int c = 0; c < 2; c++) begin
      base = 'h802A + 3 * c;
      if (rd && addr == base) begin
        m_snap[c] = int'(m_pkt[c] % 65536);
        if (m_ctrl[1]) m_pkt[c] = 0;
      end
      m_pkt[c] = (m_pkt[c] + fe[c]) % 64'h1_0000_0000;
      if (rd && addr == base + 2 && m_ctrl[1]) m_err[c] = 0;
      if (fe[c] && bad[c] && m_ctrl[0] && m_err[c] < 65535) m_err[c]++;
    end
    if (wr && addr == A_CTRL) m_ctrl = wdata & 3;
  endtask

  task automatic step(input bit rfe, input bit rbad, input bit tfe, input bit tbad,
                      input bit rd, input bit wr, input logic [15:0] addr,
                      input logic [15:0] wdata);
    @(negedge clk);
    rx_frame_end = rfe; rx_crc_bad = rbad; tx_frame_end = tfe; tx_crc_bad = tbad;
    mgmt_rd = rd; mgmt_wr = wr; mgmt_addr = addr; mgmt_wdata = wdata;
    model_edge({tfe, rfe}, {tbad, rbad}, rd, wr, int'(addr), int'(wdata));
    @(posedge clk); #1;
    check("R11 rdata vs model", int'(mgmt_rdata), m_rdata);
  endtask

  task automatic rd_reg(input logic [15:0] addr, input int exp, input string tag);
    step(0, 0, 0, 0, 1, 0, addr, 16'h0);
    check(tag, int'(mgmt_rdata), exp);
  endtask

  task automatic wr_ctrl(input logic [15:0] v);
    step(0, 0, 0, 0, 0, 1, A_CTRL, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin m_pkt[c] = 0; m_err[c] = 0; m_snap[c] = 0; end
    repeat (3) @(posedge clk);
    #1 check("R1 rdata in reset", int'(mgmt_rdata), 0);
    @(negedge clk); rst_n = 1'b1;

    // R1: everything zero after reset
    rd_reg(A_CTRL, 0, "R1 ctrl");
    rd_reg(A_RXH, 0, "R1 rx hi");
    rd_reg(A_RXL, 0, "R1 rx lo");
    rd_reg(A_RXE, 0, "R1 rx err");
    rd_reg(A_TXH, 0, "R1 tx hi");
    rd_reg(A_TXL, 0, "R1 tx lo");
    rd_reg(A_TXE, 0, "R1 tx err");

    // R4: CRC check off, bad frames not counted as errors
    repeat (3) step(1, 1, 0, 0, 0, 0, 16'h0, 16'h0);
    rd_reg(A_RXE, 0, "R4 no errors while disabled");
    rd_reg(A_RXH, 0, "R3 rx hi");
    rd_reg(A_RXL, 3, "R3 rx lo counts bad frames");

    // R4 with CRC check on
    wr_ctrl(16'h0001);
    repeat (2) step(1, 1, 0, 0, 0, 0, 16'h0, 16'h0);
    step(0, 0, 1, 1, 0, 0, 16'h0, 16'h0);
    repeat (4) step(0, 0, 1, 0, 0, 0, 16'h0, 16'h0);
    rd_reg(A_RXE, 2, "R4 rx errors");
    rd_reg(A_TXE, 1, "R4 tx errors");
    rd_reg(A_TXH, 0, "R3 tx hi");
    rd_reg(A_TXL, 5, "R3 tx lo");
    // R9: non-destructive reads
    rd_reg(A_RXE, 2, "R9 rx err reread");
    rd_reg(A_RXH, 0, "R9 rx hi");
    rd_reg(A_RXL, 5, "R9 rx lo reread");

    // R2: control register
    rd_reg(A_CTRL, 1, "R2 ctrl readback");
    wr_ctrl(16'hFFFF);
    rd_reg(A_CTRL, 3, "R2 upper bits zero");

    // R6/R7: snapshot and clear-on-read
    rd_reg(A_RXH, 0, "R7 rx hi clearing");
    step(1, 0, 0, 0, 0, 0, 16'h0, 16'h0);
    rd_reg(A_RXL, 5, "R6 lo from snapshot");
    rd_reg(A_RXH, 0, "R7 rx hi again");
    rd_reg(A_RXL, 1, "R7 count restarted after clear");
    rd_reg(A_RXE, 2, "R7 rx err before clear");
    rd_reg(A_RXE, 0, "R7 rx err cleared");

    // R8: event in the clearing cycle
    step(1, 0, 0, 0, 1, 0, A_RXH, 16'h0);
    check("R8 rx hi during event", int'(mgmt_rdata), 0);
    rd_reg(A_RXH, 0, "R8 rx hi");
    rd_reg(A_RXL, 1, "R8 event kept on pkt clear");
    step(0, 0, 1, 1, 1, 0, A_TXE, 16'h0);
    check("R8 tx err read", int'(mgmt_rdata), 1);
    rd_reg(A_TXE, 1, "R8 event kept on err clear");

    // R10: unmapped access
    rd_reg(16'h8028, 0, "R10 below map");
    rd_reg(16'h8030, 0, "R10 above map");
    rd_reg(16'h0000, 0, "R10 zero address");
    step(0, 0, 0, 0, 0, 1, A_TXL, 16'h1234);
    rd_reg(A_TXH, 0, "R10 tx hi untouched");
    rd_reg(A_TXL, 6, "R10 tx lo untouched");
    rd_reg(A_CTRL, 3, "R10 ctrl untouched");

    // R5: saturation, and R6 half split above bit 15
    wr_ctrl(16'h0001);
    for (int i = 0; i < 65540; i++) step(0, 0, 1, 1, 0, 0, 16'h0, 16'h0);
    rd_reg(A_TXE, 16'hFFFF, "R5 tx err saturated");
    rd_reg(A_TXH, 1, "R6 tx hi after carry");
    rd_reg(A_TXL, 4, "R6 tx lo after carry");
    step(0, 0, 1, 1, 0, 0, 16'h0, 16'h0);
    rd_reg(A_TXE, 16'hFFFF, "R5 stays saturated");
    repeat (3) step(0, 0, 0, 0, 0, 0, 16'h0, 16'h0);
    check("R11 rdata held", int'(mgmt_rdata), 16'hFFFF);
    rd_reg(A_RXE, 0, "R4 rx err untouched by tx");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule